// File: doc/BRIEF.md
# Per-Bank Command Timing Tracker

This block keeps the earliest legal issue cycle for row-open, row-close and column commands on every bank of one memory rank. It watches a stream of command reports on a single input port (one command per cycle at most). Each report moves the affected earliest-issue times forward. A free-running cycle counter is compared against those times, and the result drives three per-bank ready vectors. A scheduler elsewhere reads the vectors to pick legal commands. The tracker itself never generates a command.

Banks are arranged in groups. Bank `b` belongs to group `b mod NUM_GROUPS`, and the bank count must be a multiple of the group count. Row opens are spaced more widely inside a group than across groups. A rolling window limits how many row opens may occur within a span of cycles: the block keeps a short history of recent open times and, once that history is full, holds every bank back until the oldest recorded open has aged out of the window. Times only ever move later.

A command that arrives when its target bank is not ready is rejected. The block raises a one-cycle error flag and leaves all timing state untouched.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, `now` reads 0, every bank is closed, `act_ready` is all ones, `pre_ready` and `col_ready` are all zeros, and `cmd_err` is 0.
- R2: A legal open (`cmd_kind` 0) at cycle t keeps every other bank of the same group (group = bank mod NUM_GROUPS) from showing `act_ready` before cycle t+T_RRD_SAME.
- R3: A legal open at cycle t keeps every bank of a different group from showing `act_ready` before cycle t+T_RRD_DIFF.
- R4: A legal open at cycle t marks the target bank open: its `act_ready` drops, `pre_ready` rises, and `col_ready` rises first at cycle t+T_RCD. A closed bank never shows `col_ready` or `pre_ready`, and an open bank never shows `act_ready`.
- R5: Once ACT_LIMIT opens are recorded, each further legal open (the one filling the history included) keeps every bank from opening before the oldest recorded open time plus T_WINDOW.
- R6: A legal close (`cmd_kind` 1) at cycle t closes the target bank, keeps every bank from showing `pre_ready` before t+T_PPD, and keeps the closed bank from showing `act_ready` before t+T_RP.
- R7: A legal read (`cmd_kind` 2) or write (`cmd_kind` 3) at cycle t keeps every bank from showing `col_ready` before t+T_CCD.
- R8: Each earliest-issue time takes the maximum of its stored value and any new bound, so a later command never makes a bank ready sooner.
- R9: A command whose target bank does not show the ready flag for its kind sets `cmd_err` in the following cycle only and changes no timing or open state.
- R10: `now` advances by exactly one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is reported this cycle |
| cmd_kind | input | 2 | 0 open, 1 close, 2 read, 3 write |
| cmd_bank | input | BW | Target bank index |
| act_ready | output | NUM_BANKS | Bank may be opened this cycle |
| pre_ready | output | NUM_BANKS | Bank may be closed this cycle |
| col_ready | output | NUM_BANKS | Bank may take a read or write this cycle |
| cmd_err | output | 1 | Previous cycle's command was rejected |
| now | output | TW | Free-running cycle counter |

## Verification
The properties are checked on every cycle. They cover the counter step, the rule that a bank is never open-ready and column-ready together, the error pulse that follows a rejected command, the absence of an error after a legal one, and the immediate effect of opens, closes and column commands on the target bank. The exact cycle at which a bank becomes ready again is checked only by the bench scenarios. These include same-group versus cross-group spacing, the window bound winning over a shorter close-to-open delay, and the proof that a rejected command left each timer where it was.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    BT_OPEN  = 2'd0,
    BT_CLOSE = 2'd1,
    BT_RD    = 2'd2,
    BT_WR    = 2'd3
  } bt_cmd_e;

  function automatic int bank_group(input int bank, input int groups);
    return bank % groups;
  endfunction

endpackage

// File: rtl/bt_act_window.sv
module bt_act_window #(
  parameter int TW        = 32,
  parameter int ACT_LIMIT = 4,
  parameter int T_WINDOW  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_time,
  output logic          floor_en,
  output logic [TW-1:0] floor_val
);

  localparam int CW = $clog2(ACT_LIMIT + 1);
  localparam logic [TW-1:0] D_WIN = TW'(T_WINDOW);

  logic [TW-1:0] hist_q [ACT_LIMIT];
  logic [TW-1:0] hist_d [ACT_LIMIT];
  logic [CW-1:0] fill_q, fill_d;
  logic [TW-1:0] oldest;

  generate
    if (ACT_LIMIT == 1) begin : g_one
      assign oldest = push_time;
    end else begin : g_many
      assign oldest = hist_q[ACT_LIMIT-2];
    end
  endgenerate

  assign floor_en  = push && (fill_q >= CW'(ACT_LIMIT - 1));
  assign floor_val = oldest + D_WIN;

  always_comb begin
    for (int i = 0; i < ACT_LIMIT; i++) hist_d[i] = hist_q[i];
    fill_d = fill_q;
    if (push) begin
      hist_d[0] = push_time;
      for (int i = 1; i < ACT_LIMIT; i++) hist_d[i] = hist_q[i-1];
      if (fill_q != CW'(ACT_LIMIT)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACT_LIMIT; i++) hist_q[i] <= '0;
      fill_q <= '0;
    end else if (push) begin
      for (int i = 0; i < ACT_LIMIT; i++) hist_q[i] <= hist_d[i];
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/bt_bank_slot.sv
module bt_bank_slot #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now,
  input  logic          act_en,
  input  logic [TW-1:0] act_floor,
  input  logic          pre_en,
  input  logic [TW-1:0] pre_floor,
  input  logic          col_en,
  input  logic [TW-1:0] col_floor,
  input  logic          open_set,
  input  logic          open_clr,
  output logic          act_rdy,
  output logic          pre_rdy,
  output logic          col_rdy
);

  logic [TW-1:0] act_at_q, act_at_d;
  logic [TW-1:0] pre_at_q, pre_at_d;
  logic [TW-1:0] col_at_q, col_at_d;
  logic          open_q, open_d;
  logic          upd;

  assign upd = act_en | pre_en | col_en | open_set | open_clr;

  always_comb begin
    act_at_d = act_at_q;
    pre_at_d = pre_at_q;
    col_at_d = col_at_q;
    open_d   = open_q;
    if (act_en && (act_floor > act_at_q)) act_at_d = act_floor;
    if (pre_en && (pre_floor > pre_at_q)) pre_at_d = pre_floor;
    if (col_en && (col_floor > col_at_q)) col_at_d = col_floor;
    if (open_set)      open_d = 1'b1;
    else if (open_clr) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_at_q <= '0;
      pre_at_q <= '0;
      col_at_q <= '0;
      open_q   <= 1'b0;
    end else if (upd) begin
      act_at_q <= act_at_d;
      pre_at_q <= pre_at_d;
      col_at_q <= col_at_d;
      open_q   <= open_d;
    end
  end

  assign act_rdy = !open_q && (now >= act_at_q);
  assign pre_rdy =  open_q && (now >= pre_at_q);
  assign col_rdy =  open_q && (now >= col_at_q);

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
  parameter int TW         = 32,
  parameter int NUM_BANKS  = 4,
  parameter int NUM_GROUPS = 2,
  parameter int ACT_LIMIT  = 4,
  parameter int T_RRD_DIFF = 2,
  parameter int T_RRD_SAME = 4,
  parameter int T_WINDOW   = 20,
  parameter int T_RCD      = 3,
  parameter int T_RP       = 5,
  parameter int T_PPD      = 2,
  parameter int T_CCD      = 2,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_kind,
  input  logic [BW-1:0]        cmd_bank,
  output logic [NUM_BANKS-1:0] act_ready,
  output logic [NUM_BANKS-1:0] pre_ready,
  output logic [NUM_BANKS-1:0] col_ready,
  output logic                 cmd_err,
  output logic [TW-1:0]        now
);
  import bt_pkg::*;

  localparam logic [TW-1:0] D_RRD_DIFF = TW'(T_RRD_DIFF);
  localparam logic [TW-1:0] D_RRD_SAME = TW'(T_RRD_SAME);
  localparam logic [TW-1:0] D_RCD      = TW'(T_RCD);
  localparam logic [TW-1:0] D_RP       = TW'(T_RP);
  localparam logic [TW-1:0] D_PPD      = TW'(T_PPD);
  localparam logic [TW-1:0] D_CCD      = TW'(T_CCD);

  bt_cmd_e       kind;
  logic          tgt_rdy;
  logic          legal;
  logic          do_open, do_close, do_col;
  logic [TW-1:0] now_d;
  logic          err_d;
  int            tgt_grp;
  logic          win_en;
  logic [TW-1:0] win_floor;
  logic [TW-1:0] pre_fl;

  assign kind = bt_cmd_e'(cmd_kind);

  always_comb begin
    case (kind)
      BT_OPEN:  tgt_rdy = act_ready[cmd_bank];
      BT_CLOSE: tgt_rdy = pre_ready[cmd_bank];
      default:  tgt_rdy = col_ready[cmd_bank];
    endcase
  end

  assign legal    = cmd_valid && tgt_rdy;
  assign do_open  = legal && (kind == BT_OPEN);
  assign do_close = legal && (kind == BT_CLOSE);
  assign do_col   = legal && ((kind == BT_RD) || (kind == BT_WR));
  assign tgt_grp  = bank_group(int'(cmd_bank), NUM_GROUPS);
  assign pre_fl   = now + D_PPD;

  assign now_d = now + 1'b1;
  assign err_d = cmd_valid && !tgt_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now     <= '0;
      cmd_err <= 1'b0;
    end else begin
      now     <= now_d;
      cmd_err <= err_d;
    end
  end

  bt_act_window #(
    .TW(TW), .ACT_LIMIT(ACT_LIMIT), .T_WINDOW(T_WINDOW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_open),
    .push_time (now),
    .floor_en  (win_en),
    .floor_val (win_floor)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int GRP = bank_group(b, NUM_GROUPS);
      logic          is_tgt;
      logic          same_grp;
      logic          a_en, c_en;
      logic [TW-1:0] a_fl, c_fl;

      assign is_tgt   = (cmd_bank == BW'(b));
      assign same_grp = (tgt_grp == GRP);

      always_comb begin
        a_en = 1'b0;
        a_fl = '0;
        if (do_open && !is_tgt) begin
          a_en = 1'b1;
          a_fl = same_grp ? (now + D_RRD_SAME) : (now + D_RRD_DIFF);
        end
        if (win_en && (win_floor > a_fl)) begin
          a_en = 1'b1;
          a_fl = win_floor;
        end
        if (do_close && is_tgt) begin
          a_en = 1'b1;
          a_fl = now + D_RP;
        end
        c_en = 1'b0;
        c_fl = '0;
        if (do_open && is_tgt) begin
          c_en = 1'b1;
          c_fl = now + D_RCD;
        end
        if (do_col) begin
          c_en = 1'b1;
          c_fl = now + D_CCD;
        end
      end

      bt_bank_slot #(.TW(TW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (now),
        .act_en    (a_en),
        .act_floor (a_fl),
        .pre_en    (do_close),
        .pre_floor (pre_fl),
        .col_en    (c_en),
        .col_floor (c_fl),
        .open_set  (do_open && is_tgt),
        .open_clr  (do_close && is_tgt),
        .act_rdy   (act_ready[b]),
        .pre_rdy   (pre_ready[b]),
        .col_rdy   (col_ready[b])
      );
    end
  endgenerate

endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int TW        = 32,
  parameter int NUM_BANKS = 4,
  parameter int T_CCD     = 2,
  parameter int T_RP      = 5,
  parameter int BW        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_kind,
  input logic [BW-1:0]        cmd_bank,
  input logic [NUM_BANKS-1:0] act_ready,
  input logic [NUM_BANKS-1:0] pre_ready,
  input logic [NUM_BANKS-1:0] col_ready,
  input logic                 cmd_err,
  input logic [TW-1:0]        now
);

  logic sel_rdy;
  always_comb begin
    case (cmd_kind)
      2'd0:    sel_rdy = act_ready[cmd_bank];
      2'd1:    sel_rdy = pre_ready[cmd_bank];
      default: sel_rdy = col_ready[cmd_bank];
    endcase
  end

  assert_now_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now == $past(now) + 1'b1);

  // R4: a bank is open-ready or column-ready, never both
  assert_state_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ready & col_ready) == '0);

  assert_reject_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !sel_rdy) |=> cmd_err);

  assert_accept_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || sel_rdy) |=> !cmd_err);

  assert_open_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd0 && sel_rdy)
      |=> !act_ready[$past(cmd_bank)] && pre_ready[$past(cmd_bank)]);

  assert_close_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1 && sel_rdy && T_RP > 1)
      |=> !act_ready[$past(cmd_bank)] && !pre_ready[$past(cmd_bank)]);

  assert_col_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1] && sel_rdy && T_CCD > 1) |=> col_ready == '0);

endmodule

bind bank_timing_tracker bt_checker #(
  .TW(TW), .NUM_BANKS(NUM_BANKS), .T_CCD(T_CCD), .T_RP(T_RP), .BW(BW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .cmd_bank  (cmd_bank),
  .act_ready (act_ready),
  .pre_ready (pre_ready),
  .col_ready (col_ready),
  .cmd_err   (cmd_err),
  .now       (now)
);

// File: tb/bank_timing_tracker_tb.sv
`timescale 1ns/1ps
module bank_timing_tracker_tb;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [1:0]  cmd_bank;
  logic [3:0]  act_ready, pre_ready, col_ready;
  logic        cmd_err;
  logic [31:0] now;

  int vecs;
  int errs;
  bit done;

  bank_timing_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .act_ready(act_ready), .pre_ready(pre_ready),
    .col_ready(col_ready), .cmd_err(cmd_err), .now(now)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s at now=%0d: got %0h expected %0h", req, now, got, exp);
    end
  endtask

  task automatic wait_now(input int t);
    while (now != 32'(t)) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] k, input logic [1:0] b);
    cmd_valid = 1'b1;
    cmd_kind  = k;
    cmd_bank  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    vecs = 0; errs = 0; done = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 2'd0; cmd_bank = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 now", now, 0);
    chk("R1 act_ready", 32'(act_ready), 32'hF);
    chk("R1 pre_ready", 32'(pre_ready), 0);
    chk("R1 col_ready", 32'(col_ready), 0);
    chk("R1 cmd_err", 32'(cmd_err), 0);
    @(negedge clk);
    chk("R10 step", now, 1);

    wait_now(4);
    issue(2'd0, 2'd0);                      // open bank0 at 4
    // now 5
    chk("R2 R3 R4 act_ready", 32'(act_ready), 32'h0);
    chk("R4 pre_ready", 32'(pre_ready), 32'h1);
    chk("R4 col before tRCD", 32'(col_ready), 0);
    issue(2'd0, 2'd2);                      // illegal open bank2 at 5
    // now 6
    chk("R9 err pulse", 32'(cmd_err), 1);
    chk("R3 cross-group ready", 32'(act_ready), 32'hA);
    @(negedge clk);                         // now 7
    chk("R4 col at tRCD", 32'(col_ready), 32'h1);
    chk("R9 err single", 32'(cmd_err), 0);
    chk("R2 same-group held", 32'(act_ready), 32'hA);
    @(negedge clk);                         // now 8
    chk("R2 R9 same-group ready, reject had no effect", 32'(act_ready), 32'hE);

    issue(2'd0, 2'd1);                      // open bank1 at 8
    // now 9
    chk("R3 R2 after bank1 open", 32'(act_ready), 32'h0);
    wait_now(10);
    chk("R3 bank2 ready at 10", 32'(act_ready), 32'h4);
    issue(2'd0, 2'd2);                      // open bank2 at 10
    wait_now(12);
    chk("R2 bank3 ready at 12", 32'(act_ready), 32'h8);
    issue(2'd0, 2'd3);                      // open bank3 at 12, history full
    issue(2'd1, 2'd0);                      // close bank0 at 13
    // now 14
    chk("R6 tPPD hold", 32'(pre_ready), 0);
    chk("R5 closed bank held", 32'(act_ready), 0);
    @(negedge clk);                         // now 15
    chk("R6 tPPD release", 32'(pre_ready), 32'hE);
    wait_now(23);
    chk("R5 R8 window beats tRP", 32'(act_ready), 0);
    @(negedge clk);                         // now 24
    chk("R5 window release", 32'(act_ready), 32'h1);

    issue(2'd1, 2'd1);                      // close bank1 at 24
    // now 25
    chk("R6 tPPD after second close", 32'(pre_ready), 0);
    @(negedge clk);                         // now 26
    chk("R6 pre release", 32'(pre_ready), 32'hC);
    wait_now(28);
    chk("R6 tRP hold", 32'(act_ready), 32'h1);
    @(negedge clk);                         // now 29
    chk("R6 tRP release", 32'(act_ready), 32'h3);

    issue(2'd2, 2'd2);                      // read bank2 at 29
    // now 30
    chk("R7 col gap", 32'(col_ready), 0);
    issue(2'd2, 2'd0);                      // read closed bank0, illegal
    // now 31
    chk("R9 err on closed read", 32'(cmd_err), 1);
    chk("R7 R9 col release unaffected", 32'(col_ready), 32'hC);
    issue(2'd3, 2'd3);                      // write bank3 at 31
    // now 32
    chk("R7 write gap", 32'(col_ready), 0);
    chk("R9 no err on legal", 32'(cmd_err), 0);
    @(negedge clk);                         // now 33
    chk("R7 write release", 32'(col_ready), 32'hC);
    issue(2'd1, 2'd0);                      // close closed bank0, illegal
    // now 34
    chk("R9 err on closed close", 32'(cmd_err), 1);
    chk("R9 act unaffected", 32'(act_ready), 32'h3);
    chk("R9 pre unaffected", 32'(pre_ready), 32'hC);
    chk("R10 counter", now, 34);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule